// File: doc/BRIEF.md
# Boot ROM Shadow Overlay

After reset this block lays a 32-byte loader ROM over the lowest addresses of the memory map, so a processor can fetch its first instructions before RAM holds any code. While the overlay is armed, any read that falls inside the ROM window (addresses 0x0000 to 0x001F) is answered from the ROM. During such a read the block raises a phantom output that tells the RAM board to keep off the bus.

Writes are never taken by the overlay. They always pass through to the RAM underneath, so the loader can copy code into the low page while still running from ROM. The first read whose address has bit 5 set disarms the overlay. That read is itself served by RAM, and every later read goes to RAM until the next reset. A static strap turns the whole overlay off, in which case the block only forwards RAM data.

Top module: `boot_overlay`

## Requirements
- R1: After reset with the strap on, a read at address A in 0x0000..0x001F raises phantom in the same cycle, and rdata equals byte A of the ROM image, where byte i sits at bits [8*i+7:8*i] of the image parameter.
- R2: A write cycle never raises phantom, including writes inside the ROM window, and it leaves the overlay armed.
- R3: A read with address bit 5 set is served by RAM with phantom low, and from the following cycle on, reads in the window are served by RAM with phantom low.
- R4: A read at or above 0x0020 with bit 5 clear (for example 0x0040) is served by RAM and does not disarm the overlay.
- R5: A reset with the strap on re-arms the overlay after it has been disarmed.
- R6: With the strap off, phantom never rises and every read is served by RAM, including reads in the window.
- R7: When a read is not served by the ROM and ram_ack is low, rdata is 0xFF. rdata is also 0xFF whenever rd is low.
- R8: Phantom is low whenever rd is low, even while the address lies in the window and the overlay is armed.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; re-arms the overlay when the strap is on |
| strap_en | input | 1 | Static strap that enables the overlay |
| addr | input | ADDR_W | Bus address |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| ram_rdata | input | DATA_W | Read data from the RAM board |
| ram_ack | input | 1 | High when the RAM board supplies read data |
| rdata | output | DATA_W | Read data returned to the processor |
| phantom | output | 1 | High while the ROM answers a read; RAM must not drive |

## Verification
The hardest case to reach is the boundary of the disarming read. That read must itself come from RAM, and the window read in the very next cycle must already come from RAM. The bench sets this up by issuing a read at an address with bit 5 set, placed directly before a window read, and then checks phantom and rdata in both cycles. A second case is an out-of-window read with bit 5 clear (0x0040). This read must leave the overlay armed, and the bench confirms it with a window read right after.

// File: rtl/boot_overlay.sv
module boot_overlay #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ROM_BYTES = 32,
  parameter logic [ROM_BYTES*DATA_W-1:0] ROM_IMAGE =
    256'h8796A5B4C3D2E1F0_0F1E2D3C4B5A6978_FEDCBA9876543210_0123456789ABCDEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic              ram_ack,
  output logic [DATA_W-1:0] rdata,
  output logic              phantom
);
  localparam int OFS_W = $clog2(ROM_BYTES);

  logic armed;
  logic in_win;
  logic [OFS_W-1:0] ofs;

  assign ofs     = addr[OFS_W-1:0];
  assign in_win  = (addr >> OFS_W) == '0;
  assign phantom = rd && !wr && armed && strap_en && in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed <= strap_en;
    else if (rd && addr[OFS_W])
      armed <= 1'b0;
  end

  always_comb begin
    if (phantom)
      rdata = ROM_IMAGE[DATA_W*ofs +: DATA_W];
    else if (rd && ram_ack)
      rdata = ram_rdata;
    else
      rdata = '1;
  end
endmodule

// File: rtl/boot_overlay_chk.sv
module boot_overlay_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strap_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rd,
  input logic              wr,
  input logic [DATA_W-1:0] ram_rdata,
  input logic              ram_ack,
  input logic [DATA_W-1:0] rdata,
  input logic              phantom
);
  a_r2_write_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !phantom);
  a_r3_disarm_next: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr[5]) |=> !phantom);
  a_r3_disarm_self: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr[5]) |-> !phantom);
  a_r6_strap_off: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |-> !phantom);
  a_r7_float_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!phantom && !(rd && ram_ack)) |-> (rdata == '1));
  a_r7_ram_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!phantom && rd && ram_ack) |-> (rdata == ram_rdata));
  a_r8_phantom_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
    phantom |-> (rd && addr < 32));
endmodule

bind boot_overlay boot_overlay_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .addr(addr), .rd(rd), .wr(wr),
  .ram_rdata(ram_rdata), .ram_ack(ram_ack), .rdata(rdata), .phantom(phantom)
);

// File: tb/test_boot_overlay.sv
module test_boot_overlay;
  localparam logic [255:0] IMG =
    256'h1122334455667788_99AABBCCDDEEFF00_A5A55A5AC3C33C3C_0F0FF0F012344321;

  logic clk = 0, rst_n = 0, strap_en = 1;
  logic [15:0] addr = '0;
  logic rd = 0, wr = 0, ram_ack = 0;
  logic [7:0] ram_rdata = '0;
  logic [7:0] rdata;
  logic phantom;
  int total = 0, bad = 0;
  logic [7:0] got_d;
  logic got_p;

  always #10 clk = ~clk;

  boot_overlay #(.ROM_IMAGE(IMG)) i_boot_overlay (
    .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .addr(addr), .rd(rd), .wr(wr),
    .ram_rdata(ram_rdata), .ram_ack(ram_ack), .rdata(rdata), .phantom(phantom));

  function automatic logic [7:0] ram_of(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [7:0] d, input logic p,
                     input logic [7:0] ed, input logic ep);
    total++;
    if (d !== ed || p !== ep) begin
      bad++;
      $display("FAIL %s: rdata=%h phantom=%b expected rdata=%h phantom=%b", req, d, p, ed, ep);
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic [15:0] a, input logic ack);
    @(negedge clk);
    rd = r; wr = w; addr = a; ram_ack = ack; ram_rdata = ram_of(a);
    #3;
    got_d = rdata; got_p = phantom;
    @(posedge clk);
    #1;
    rd = 0; wr = 0; ram_ack = 0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst_n = 0; strap_en = s;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_rom_reads;
    for (int i = 0; i < 32; i += 7) begin
      cyc(1, 0, 16'(i), 1);
      chk("R1", got_d, got_p, IMG[8*i +: 8], 1);
    end
    cyc(1, 0, 16'h001F, 0);
    chk("R1", got_d, got_p, IMG[8*31 +: 8], 1);
  endtask

  task automatic t_writes;
    cyc(0, 1, 16'h0003, 0);
    chk("R2", got_d, got_p, 8'hFF, 0);
    cyc(0, 1, 16'h0020, 0);
    chk("R2", got_d, got_p, 8'hFF, 0);
    cyc(1, 0, 16'h0004, 1);
    chk("R2", got_d, got_p, IMG[8*4 +: 8], 1);
  endtask

  task automatic t_idle;
    cyc(0, 0, 16'h0002, 1);
    chk("R8", got_d, got_p, 8'hFF, 0);
    chk("R7", got_d, got_p, 8'hFF, 0);
  endtask

  task automatic t_high_no_b5;
    cyc(1, 0, 16'h0040, 1);
    chk("R4", got_d, got_p, ram_of(16'h0040), 0);
    cyc(1, 0, 16'h0001, 1);
    chk("R4", got_d, got_p, IMG[8*1 +: 8], 1);
  endtask

  task automatic t_disarm;
    cyc(1, 0, 16'h0120, 1);
    chk("R3", got_d, got_p, ram_of(16'h0120), 0);
    cyc(1, 0, 16'h0005, 1);
    chk("R3", got_d, got_p, ram_of(16'h0005), 0);
    cyc(1, 0, 16'h0006, 0);
    chk("R7", got_d, got_p, 8'hFF, 0);
  endtask

  task automatic t_rearm;
    do_reset(1);
    cyc(1, 0, 16'h0005, 1);
    chk("R5", got_d, got_p, IMG[8*5 +: 8], 1);
  endtask

  task automatic t_strap_off;
    do_reset(0);
    cyc(1, 0, 16'h0000, 1);
    chk("R6", got_d, got_p, ram_of(16'h0000), 0);
    cyc(1, 0, 16'h001F, 0);
    chk("R6", got_d, got_p, 8'hFF, 0);
  endtask

  initial begin
    #1;
    total++;
    if (phantom !== 0 || rdata !== 8'hFF) begin
      bad++;
      $display("FAIL R8 reset: rdata=%h phantom=%b expected rdata=ff phantom=0", rdata, phantom);
    end
    do_reset(1);
    t_rom_reads();
    t_writes();
    t_idle();
    t_high_no_b5();
    t_disarm();
    t_rearm();
    t_strap_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    total++; bad++;
    $display("FAIL watchdog: run=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule